// File: doc/BRIEF.md
# Multifunction ALU with Split Control Word

This block is the integer ALU of a small load/store core. It takes two 32-bit operands, a 16-bit immediate and an 8-bit control word. It returns a 32-bit result with a zero flag and a signed-overflow flag. The control word does not carry a flat opcode. It is split into fields: a function class, an add/subtract select, a shift-function field and a logic-function select. Decode logic upstream only has to set each field on its own.

Control word layout, most significant bit first:

| Bits  | Field                |
|-------|----------------------|
| [7:6] | function class       |
| [5]   | add/subtract select  |
| [4:2] | shift function       |
| [1:0] | logic function       |

The function class chooses the result source:

| Class | Result source             |
|-------|---------------------------|
| 00    | upper-immediate           |
| 01    | signed less-than compare  |
| 10    | adder                     |
| 11    | bitwise logic unit        |

A small decoder is included so the datapath can be tested from a 4-bit operation kind instead of a raw control word. The `dec_en_i` input selects it.

Result and flags are captured in one register stage. A value shows on the outputs after the rising edge that samples the inputs. Immediate-operand forms (add-immediate, compare-immediate and so on) reuse the same control settings. The caller places the extended immediate on `b_i`.

Top module: `alu_mf_top`

## Requirements
- R1: While `rst_n` is low, `res_o`, `zero_o` and `ovf_o` are held at 0.
- R2: Inputs sampled at a rising clock edge produce their result and flags just after that edge. The outputs do not change between edges.
- R3: Class 10 returns `a_i + b_i` mod 2^32 when bit 5 is 0, and `a_i - b_i` mod 2^32 when bit 5 is 1.
- R4: `ovf_o` is 1 only in class 10 when the signed add or subtract overflows. An overflow is present when the effective operand signs agree and the result sign differs from them. In every other class `ovf_o` is 0.
- R5: `zero_o` is 1 when the adder output (`a_i` plus or minus `b_i`, chosen by bit 5) is all zeros. This holds in every class.
- R6: Class 01, with bit 5 set, returns 1 in bit 0 when `a_i < b_i` as signed numbers. The test is the difference sign XOR its overflow. Bits 31:1 are 0.
- R7: Class 11 applies the logic function selected by bits 1:0, where 00 is AND, 01 is OR, 10 is XOR and 11 is NOR.
- R8: Class 00 returns `{imm_i, 16'h0000}`. The shift field (bits 4:2), `a_i` and `b_i` have no effect on the result.
- R9: With `dec_en_i` high, the control word comes from `op_kind_i` and `ctrl_word_i` is ignored. The kinds map to these words:

| `op_kind_i` | Operation          | Control word |
|-------------|--------------------|--------------|
| 0           | upper-immediate    | 0x00         |
| 1           | add                | 0x80         |
| 2           | subtract           | 0xA0         |
| 3           | set-less-than      | 0x60         |
| 4           | AND                | 0xC0         |
| 5           | OR                 | 0xC1         |
| 6           | XOR                | 0xC2         |
| 7           | NOR                | 0xC3         |
| 8 to 15     | maps to word 0x00  | 0x00         |

- R10: In class 11 the add/subtract bit has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en_i | input | 1 | Take control from the built-in decoder |
| op_kind_i | input | 4 | Operation kind for the decoder |
| ctrl_word_i | input | 8 | Raw split control word |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| imm_i | input | 16 | Immediate for the upper-immediate class |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered adder-zero flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The zero flag and the overflow flag can both assert in the same cycle. This happens when an addition wraps exactly to zero, for example 0x80000000 + 0x80000000. The vector table holds that case, and the bench expects a zero result with both flags high on the same output edge. A second collision lives inside the compare class: the subtraction overflows, so the raw sign bit gives the wrong answer and the overflow correction must flip it. The bench drives both overflow directions and checks that the overflow flag stays low in that class.

// File: rtl/alu_mf_pkg.sv
package alu_mf_pkg;

    parameter int unsigned CTRL_W = 8;
    parameter int unsigned KIND_W = 4;

    typedef enum logic [1:0] {
        CLS_UPPER = 2'b00,
        CLS_SLT   = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } fn_class_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_fn_e;

    // Field order of the 8-bit control word, MSB first.
    typedef struct packed {
        fn_class_e cls;
        logic      sub;
        logic [2:0] shf;
        logic_fn_e lfn;
    } ctrl_t;

    typedef enum logic [3:0] {
        K_UPPER = 4'd0,
        K_ADD   = 4'd1,
        K_SUB   = 4'd2,
        K_SLT   = 4'd3,
        K_AND   = 4'd4,
        K_OR    = 4'd5,
        K_XOR   = 4'd6,
        K_NOR   = 4'd7
    } op_kind_e;

endpackage

// File: rtl/alu_mf_decode.sv
module alu_mf_decode
    import alu_mf_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output ctrl_t             word_o
);

    always_comb begin
        word_o = '0;
        word_o.shf = 3'b000;
        case (kind_i)
            K_ADD: begin word_o.cls = CLS_ARITH; word_o.sub = 1'b0; end
            K_SUB: begin word_o.cls = CLS_ARITH; word_o.sub = 1'b1; end
            K_SLT: begin word_o.cls = CLS_SLT;   word_o.sub = 1'b1; end
            K_AND: begin word_o.cls = CLS_LOGIC; word_o.lfn = LG_AND; end
            K_OR:  begin word_o.cls = CLS_LOGIC; word_o.lfn = LG_OR;  end
            K_XOR: begin word_o.cls = CLS_LOGIC; word_o.lfn = LG_XOR; end
            K_NOR: begin word_o.cls = CLS_LOGIC; word_o.lfn = LG_NOR; end
            default: word_o.cls = CLS_UPPER;   // R9: 0 and 8..15 give word 0x00
        endcase
    end

endmodule

// File: rtl/alu_mf_adder.sv
module alu_mf_adder #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          zero_o,
    output logic          ovf_o,
    output logic          lt_o
);

    localparam int unsigned MSB = DW - 1;

    logic [DW-1:0] b_eff;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        sum_o  = a_i + b_eff + {{(DW-1){1'b0}}, sub_i};
        zero_o = (sum_o == '0);
        // signed overflow: effective operand signs agree, result sign differs
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
        lt_o   = sum_o[MSB] ^ ovf_o;
    end

endmodule

// File: rtl/alu_mf_logic.sv
module alu_mf_logic
    import alu_mf_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic_fn_e     fn_i,
    output logic [DW-1:0] y_o
);

    always_comb begin
        case (fn_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_XOR:  y_o = a_i ^ b_i;
            default: y_o = ~(a_i | b_i);
        endcase
    end

endmodule

// File: rtl/alu_mf_top.sv
module alu_mf_top
    import alu_mf_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned IW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en_i,
    input  logic [KIND_W-1:0] op_kind_i,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [IW-1:0]     imm_i,
    output logic [DW-1:0]     res_o,
    output logic              zero_o,
    output logic              ovf_o
);

    localparam int unsigned LOW_W = DW - IW;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          zero;
        logic          ovf;
    } out_t;

    ctrl_t         dec_word;
    ctrl_t         eff;
    logic [DW-1:0] sum;
    logic          add_zero;
    logic          add_ovf;
    logic          add_lt;
    logic [DW-1:0] lg_y;
    out_t          st_d;
    out_t          st_q;

    alu_mf_decode u_dec (
        .kind_i (op_kind_i),
        .word_o (dec_word)
    );

    always_comb begin
        eff = dec_en_i ? dec_word : ctrl_t'(ctrl_word_i);
    end

    alu_mf_adder #(.DW(DW)) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (eff.sub),
        .sum_o  (sum),
        .zero_o (add_zero),
        .ovf_o  (add_ovf),
        .lt_o   (add_lt)
    );

    alu_mf_logic #(.DW(DW)) u_lg (
        .a_i  (a_i),
        .b_i  (b_i),
        .fn_i (eff.lfn),
        .y_o  (lg_y)
    );

    always_comb begin
        st_d      = st_q;
        st_d.zero = add_zero;
        st_d.ovf  = 1'b0;
        case (eff.cls)
            CLS_UPPER: st_d.res = {imm_i, {LOW_W{1'b0}}};
            CLS_SLT:   st_d.res = {{(DW-1){1'b0}}, add_lt};
            CLS_ARITH: begin
                st_d.res = sum;
                st_d.ovf = add_ovf;
            end
            default:   st_d.res = lg_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o  = st_q.res;
    assign zero_o = st_q.zero;
    assign ovf_o  = st_q.ovf;

    assert_rst_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !zero_o && !ovf_o));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eff.cls != CLS_ARITH |=> !ovf_o);

    assert_arith_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eff.cls == CLS_ARITH |=> (zero_o == (res_o == '0)));

    assert_slt_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eff.cls == CLS_SLT |=> (res_o[DW-1:1] == '0));

    assert_nor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff.cls == CLS_LOGIC && eff.lfn == LG_NOR) |=> (res_o == ~($past(a_i) | $past(b_i))));

    assert_upper_imm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eff.cls == CLS_UPPER |=> (res_o[LOW_W-1:0] == '0 && res_o[DW-1:LOW_W] == $past(imm_i)));

    assert_dec_slt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en_i && op_kind_i == K_SLT) |=> (res_o[DW-1:1] == '0 && !ovf_o));

endmodule

// File: tb/sim_alu_mf_top.sv
`timescale 1ns/1ps
module sim_alu_mf_top;

    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_en = 1'b0;
    logic [3:0]  op_kind = '0;
    logic [7:0]  ctrl = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic [31:0] res;
    logic        zf;
    logic        vf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(TCK/2) clk = ~clk;

    alu_mf_top u0 (
        .clk (clk), .rst_n (rst_n), .dec_en_i (dec_en), .op_kind_i (op_kind),
        .ctrl_word_i (ctrl), .a_i (a), .b_i (b), .imm_i (imm),
        .res_o (res), .zero_o (zf), .ovf_o (vf)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  ctrl;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic [31:0] res;
        logic        z;
        logic        v;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{4'd3,  8'h80, 32'h0000_0005, 32'h0000_0007, 16'h0000, 32'h0000_000C, 1'b0, 1'b0}, // R3 add
        '{4'd4,  8'h80, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 32'h8000_0000, 1'b0, 1'b1}, // R4 add ovf
        '{4'd3,  8'hA0, 32'h0000_0003, 32'h0000_0005, 16'h0000, 32'hFFFF_FFFE, 1'b0, 1'b0}, // R3 sub
        '{4'd4,  8'hA0, 32'h8000_0000, 32'h0000_0001, 16'h0000, 32'h7FFF_FFFF, 1'b0, 1'b1}, // R4 sub ovf
        '{4'd5,  8'hA0, 32'h0000_0009, 32'h0000_0009, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}, // R5 equal
        '{4'd5,  8'h80, 32'h8000_0000, 32'h8000_0000, 16'h0000, 32'h0000_0000, 1'b1, 1'b1}, // R5 + R4 same cycle
        '{4'd6,  8'h60, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0001, 1'b0, 1'b0}, // R6 -1<1
        '{4'd6,  8'h60, 32'h0000_0005, 32'h0000_0003, 16'h0000, 32'h0000_0000, 1'b0, 1'b0}, // R6 5<3 no
        '{4'd6,  8'h60, 32'h8000_0000, 32'h0000_0001, 16'h0000, 32'h0000_0001, 1'b0, 1'b0}, // R6 ovf corr
        '{4'd6,  8'h60, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0000, 1'b0, 1'b0}, // R6 ovf corr
        '{4'd6,  8'h60, 32'h0000_0007, 32'h0000_0007, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}, // R6 equal
        '{4'd7,  8'hC0, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 32'h00F0_1200, 1'b0, 1'b0}, // R7 AND
        '{4'd7,  8'hC1, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 32'hFFF0_FF34, 1'b0, 1'b0}, // R7 OR
        '{4'd7,  8'hC2, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 32'hFF00_ED34, 1'b0, 1'b0}, // R7 XOR
        '{4'd7,  8'hC3, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0000, 32'h000F_00CB, 1'b0, 1'b0}, // R7 NOR
        '{4'd10, 8'hE0, 32'h1234_5678, 32'h1234_5678, 16'h0000, 32'h1234_5678, 1'b1, 1'b0}, // R10 sub bit in logic
        '{4'd8,  8'h00, 32'h0000_0001, 32'h0000_0002, 16'hABCD, 32'hABCD_0000, 1'b0, 1'b0}, // R8
        '{4'd8,  8'h1C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h8001, 32'h8001_0000, 1'b0, 1'b0}, // R8 shift field
        '{4'd8,  8'h00, 32'h0000_0000, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b1, 1'b0}  // R8 zero
    };

    task automatic chk(input string tag, input logic [31:0] er, input logic ez, input logic ev);
        tests++;
        if (res !== er || zf !== ez || vf !== ev) begin
            fails++;
            $display("FAIL %s: res=%h z=%b v=%b expected res=%h z=%b v=%b",
                     tag, res, zf, vf, er, ez, ev);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one register stage).
    task automatic drive(input logic de, input logic [3:0] k, input logic [7:0] c,
                         input logic [31:0] xa, input logic [31:0] xb, input logic [15:0] xi);
        @(negedge clk);
        dec_en = de; op_kind = k; ctrl = c; a = xa; b = xb; imm = xi;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b0, 4'd0, VEC[i].ctrl, VEC[i].a, VEC[i].b, VEC[i].imm);
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].res, VEC[i].z, VEC[i].v);
        end

        // R2: new inputs are not visible before the next rising edge
        drive(1'b0, 4'd0, 8'h80, 32'd1, 32'd1, 16'h0);
        chk("R2 settle", 32'd2, 1'b0, 1'b0);
        @(negedge clk);
        ctrl = 8'h80; a = 32'd40; b = 32'd2;
        #1;
        chk("R2 held between edges", 32'd2, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 after edge", 32'd42, 1'b0, 1'b0);

        // R9: decoder overrides a conflicting raw word
        drive(1'b1, 4'd2, 8'hC3, 32'd10, 32'd4, 16'h0);
        chk("R9 kind sub", 32'd6, 1'b0, 1'b0);
        drive(1'b1, 4'd3, 8'hC3, 32'd2, 32'd9, 16'h0);
        chk("R9 kind slt", 32'd1, 1'b0, 1'b0);
        drive(1'b1, 4'd7, 8'h00, 32'd0, 32'd0, 16'h0);
        chk("R9 kind nor", 32'hFFFF_FFFF, 1'b1, 1'b0);
        drive(1'b1, 4'd0, 8'hC3, 32'd5, 32'd6, 16'h1234);
        chk("R9 kind upper", 32'h1234_0000, 1'b0, 1'b0);
        drive(1'b1, 4'd12, 8'hA0, 32'd3, 32'd3, 16'h00FF);
        chk("R9 kind out of range", 32'h00FF_0000, 1'b0, 1'b0);
        drive(1'b1, 4'd1, 8'h00, 32'hFFFF_FFFF, 32'd1, 16'h0);
        chk("R9 kind add", 32'h0, 1'b1, 1'b0);

        // R1: reset mid-run clears outputs
        @(negedge clk);
        dec_en = 1'b0; ctrl = 8'h80; a = 32'h7FFF_FFFF; b = 32'd1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 after reset", 32'h8000_0000, 1'b0, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(TCK * 5000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule